// File: doc/BRIEF.md
# Grouped Completion Interrupt Generator

This block turns per-slot completion flags from three transfer schedule types (isochronous, periodic interrupt and asynchronous) into one interrupt request for the CPU. Each schedule type has 32 descriptor slots and delivers a done vector with one bit per slot. Software programs two selection masks for each type. The "all" mask names a group of slots that must all finish before the type may interrupt. The "any" mask names slots that may interrupt on their own.

When a type's condition holds, the block can delay the interrupt by a programmed number of 125 µs microframe ticks. With a latency of zero it raises the interrupt in the same cycle. Once it fires, a per-type cause bit latches and keeps the interrupt line high until software clears that bit with a write-one-to-clear access. Software programs the masks and the latency through a small single-cycle register interface and reads them back through the same interface.

Top module: `done_group_irq`

## Requirements
- R1: After reset, `irq_o` is 0, `cause_o` is 0, and every register address reads back 0.
- R2: The register map is as follows. Address 2t holds the "all" mask of type t and address 2t+1 holds its "any" mask, where type 0 is isochronous, 1 is periodic interrupt and 2 is asynchronous. Address 6 holds the latency in bits [7:0]. Address 7 reads the cause bits in bits [2:0]. A write takes effect on the clock edge where `reg_wr_en_i` is high. Reads are combinational, and unmapped addresses read 0.
- R3: A type's "all" condition holds when its "all" mask is non-zero and every selected slot has its done bit set. If only part of the group is done, the type does not fire.
- R4: An "all" mask of zero never satisfies the "all" condition, even when every done bit of that type is set.
- R5: A type's "any" condition holds when at least one slot selected in its "any" mask has its done bit set.
- R6: Done bits of slots selected in neither mask have no effect on `irq_o` or `cause_o`.
- R7: With latency 0, `irq_o` rises combinationally in the cycle the condition becomes true. The cause bit is set at the following clock edge.
- R8: With latency N>0, `irq_o` rises during the Nth cycle with `uframe_tick_i` high, counted from when the condition became true. It stays low before that cycle.
- R9: If a type's condition drops before its latency expires, that type's tick count restarts from zero.
- R10: A cause bit stays set after the done bits clear. `irq_o` is high whenever any cause bit is set.
- R11: Writing address 7 clears each cause bit whose write-data bit is 1. Bits written with 0 are unchanged. If the condition is still true with latency 0, the cleared type fires again.
- R12: Types are independent: a condition on type t sets only cause bit t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| done_iso_i | input | 32 | Per-slot done flags, isochronous type |
| done_per_i | input | 32 | Per-slot done flags, periodic interrupt type |
| done_asy_i | input | 32 | Per-slot done flags, asynchronous type |
| uframe_tick_i | input | 1 | One-cycle pulse per microframe |
| irq_o | output | 1 | Interrupt request to the CPU |
| cause_o | output | 3 | Latched per-type cause bits |

## Verification
The hardest situation to reach from the ports is a holdoff window that is interrupted. The condition has to be true for fewer ticks than the latency, then drop, then return. The bench must then show that the earlier ticks no longer count. The bench reaches this by driving `uframe_tick_i` as single-cycle pulses under its own control and toggling a done bit between them. It samples `irq_o` in the very cycle of each pulse. The same scheme separates the combinational rise at latency 0 from the registered cause bit one edge later.

// File: rtl/dgi_pkg.sv
// Package: shared constants for the grouped completion interrupt generator.
// Assumes three schedule types, indexed 0 (isochronous), 1 (periodic), 2 (async).
package dgi_pkg;

    localparam int NUM_TYPES = 3;

    typedef enum logic [1:0] {
        SCHED_ISO = 2'd0,
        SCHED_PER = 2'd1,
        SCHED_ASY = 2'd2
    } sched_e;

    // Register address of the "all" mask of a type
    function automatic int all_addr(input int t);
        return 2 * t;
    endfunction

    // Register address of the "any" mask of a type
    function automatic int any_addr(input int t);
        return 2 * t + 1;
    endfunction

    localparam int ADDR_LAT   = 2 * NUM_TYPES;
    localparam int ADDR_CAUSE = 2 * NUM_TYPES + 1;

endpackage

// File: rtl/dgi_regs.sv
// Module: dgi_regs
// Holds the per-type "all"/"any" selection masks and the latency setting.
// Decodes write-one-to-clear strobes for the cause register.
// Provides combinational read-back.
// Assumes LAT_W <= SLOTS and NT <= SLOTS so that fields fit in one data word.
module dgi_regs #(
    parameter int SLOTS  = 32,
    parameter int NT     = 3,
    parameter int LAT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [SLOTS-1:0]          wdata,
    input  logic [NT-1:0]             cause_q,
    output logic [NT-1:0][SLOTS-1:0]  all_mask,
    output logic [NT-1:0][SLOTS-1:0]  any_mask,
    output logic [LAT_W-1:0]          latency,
    output logic [NT-1:0]             clr,
    output logic [SLOTS-1:0]          rdata
);
    import dgi_pkg::*;

    localparam logic [ADDR_W-1:0] A_LAT   = ADDR_W'(ADDR_LAT);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(ADDR_CAUSE);

    logic [NT-1:0][SLOTS-1:0] all_q;
    logic [NT-1:0][SLOTS-1:0] any_q;
    logic [LAT_W-1:0]         lat_q;

    // Register writes for masks and latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_q <= '0;
            any_q <= '0;
            lat_q <= '0;
        end else if (wr_en) begin
            for (int t = 0; t < NT; t++) begin
                if (addr == ADDR_W'(all_addr(t))) all_q[t] <= wdata;
                if (addr == ADDR_W'(any_addr(t))) any_q[t] <= wdata;
            end
            if (addr == A_LAT) lat_q <= wdata[LAT_W-1:0];
        end
    end

    // Write-one-to-clear strobes for the cause bits
    always_comb begin
        clr = '0;
        if (wr_en && addr == A_CAUSE) clr = wdata[NT-1:0];
    end

    // Combinational read-back multiplexer
    always_comb begin
        rdata = '0;
        for (int t = 0; t < NT; t++) begin
            if (addr == ADDR_W'(all_addr(t))) rdata = all_q[t];
            if (addr == ADDR_W'(any_addr(t))) rdata = any_q[t];
        end
        if (addr == A_LAT)   rdata = SLOTS'(lat_q);
        if (addr == A_CAUSE) rdata = SLOTS'(cause_q);
    end

    assign all_mask = all_q;
    assign any_mask = any_q;
    assign latency  = lat_q;

endmodule

// File: rtl/dgi_cond.sv
// Module: dgi_cond
// Evaluates each type's group condition from its done vector and masks.
// "All" needs a non-empty mask fully covered by done bits.
// "Any" needs one selected done bit.
// Purely combinational. Assumes done vectors are stable within a cycle.
module dgi_cond #(
    parameter int SLOTS = 32,
    parameter int NT    = 3
) (
    input  logic [NT-1:0][SLOTS-1:0] done,
    input  logic [NT-1:0][SLOTS-1:0] all_mask,
    input  logic [NT-1:0][SLOTS-1:0] any_mask,
    output logic [NT-1:0]            cond
);
    for (genvar t = 0; t < NT; t++) begin : g_type
        logic all_hit;
        logic any_hit;

        // Group condition: every selected slot finished, mask non-empty
        always_comb begin
            all_hit = (|all_mask[t]) && ((done[t] & all_mask[t]) == all_mask[t]);
        end

        // Individual condition: any selected slot finished
        always_comb begin
            any_hit = |(done[t] & any_mask[t]);
        end

        assign cond[t] = all_hit | any_hit;
    end

endmodule

// File: rtl/dgi_holdoff.sv
// Module: dgi_holdoff
// Per-type latency counter. While the condition holds and the cause bit
// is clear, it counts microframe ticks. It fires on the tick that makes
// the count reach the latency, or at once when the latency is zero.
// Assumes the tick is a one-cycle pulse.
module dgi_holdoff #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond,
    input  logic             pending,
    input  logic             tick,
    input  logic [LAT_W-1:0] latency,
    output logic             fire
);
    localparam logic [LAT_W-1:0] CNT_MAX = '1;

    logic [LAT_W-1:0] cnt_q;
    logic             waiting;
    logic             due;

    assign waiting = cond && !pending;

    // Tick counter: restarts whenever the wait is broken
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (!waiting)                  cnt_q <= '0;
        else if (tick && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end

    // Expiry check, widened to avoid underflow of latency-1
    always_comb begin
        due = ({1'b0, cnt_q} + (LAT_W+1)'(1)) >= {1'b0, latency};
    end

    assign fire = waiting && ((latency == '0) || (tick && due));

endmodule

// File: rtl/done_group_irq.sv
// Module: done_group_irq (top)
// Combines the register block, condition evaluator and one holdoff counter
// per schedule type. It keeps the sticky cause bits and drives the interrupt line.
// Assumes all inputs are synchronous to clk.
module done_group_irq #(
    parameter int SLOTS  = 32,
    parameter int LAT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [SLOTS-1:0]  reg_wdata_i,
    output logic [SLOTS-1:0]  reg_rdata_o,
    input  logic [SLOTS-1:0]  done_iso_i,
    input  logic [SLOTS-1:0]  done_per_i,
    input  logic [SLOTS-1:0]  done_asy_i,
    input  logic              uframe_tick_i,
    output logic              irq_o,
    output logic [2:0]        cause_o
);
    import dgi_pkg::*;

    localparam int NT = NUM_TYPES;

    logic [NT-1:0][SLOTS-1:0] done_vec;
    logic [NT-1:0][SLOTS-1:0] all_mask;
    logic [NT-1:0][SLOTS-1:0] any_mask;
    logic [LAT_W-1:0]         lat_q;
    logic [NT-1:0]            clr_vec;
    logic [NT-1:0]            cond_vec;
    logic [NT-1:0]            fire_vec;
    logic [NT-1:0]            cause_q;

    assign done_vec[SCHED_ISO] = done_iso_i;
    assign done_vec[SCHED_PER] = done_per_i;
    assign done_vec[SCHED_ASY] = done_asy_i;

    dgi_regs #(
        .SLOTS (SLOTS),
        .NT    (NT),
        .LAT_W (LAT_W),
        .ADDR_W(ADDR_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .cause_q (cause_q),
        .all_mask(all_mask),
        .any_mask(any_mask),
        .latency (lat_q),
        .clr     (clr_vec),
        .rdata   (reg_rdata_o)
    );

    dgi_cond #(
        .SLOTS(SLOTS),
        .NT   (NT)
    ) cond_i (
        .done    (done_vec),
        .all_mask(all_mask),
        .any_mask(any_mask),
        .cond    (cond_vec)
    );

    for (genvar t = 0; t < NT; t++) begin : g_hold
        dgi_holdoff #(
            .LAT_W(LAT_W)
        ) hold_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond   (cond_vec[t]),
            .pending(cause_q[t]),
            .tick   (uframe_tick_i),
            .latency(lat_q),
            .fire   (fire_vec[t])
        );
    end

    // Sticky cause bits: set by fire, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_vec) | fire_vec;
    end

    assign irq_o   = (|cause_q) || (|fire_vec);
    assign cause_o = cause_q;

endmodule

// File: rtl/dgi_checker.sv
// Module: dgi_checker
// Temporal checks on the interrupt generator. It is bound to done_group_irq
// and observes its ports plus the condition vector and latency setting.
module dgi_checker #(
    parameter int SLOTS  = 32,
    parameter int LAT_W  = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [SLOTS-1:0]  reg_wdata_i,
    input logic              uframe_tick_i,
    input logic              irq_o,
    input logic [2:0]        cause_o,
    input logic [2:0]        cond_vec,
    input logic [LAT_W-1:0]  latency
);
    logic [2:0] wclr;
    logic [2:0] keep;

    assign wclr = (reg_wr_en_i && reg_addr_i == ADDR_W'(dgi_pkg::ADDR_CAUSE))
                  ? reg_wdata_i[2:0] : 3'b000;
    assign keep = cause_o & ~wclr;

    // R10
    cause_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o != 3'b000) |-> irq_o);

    // R11
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_o & $past(keep)) == $past(keep)));

    // R3
    cause_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(cond_vec)) == 3'b000));

    // R8
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_o & ~$past(cause_o)) != 3'b000 && $past(rst_n))
        |-> ($past(latency) == '0 || $past(uframe_tick_i)));

    // R7
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cause_o != 3'b000 || cond_vec != 3'b000));

endmodule

bind done_group_irq dgi_checker #(
    .SLOTS (SLOTS),
    .LAT_W (LAT_W),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en_i  (reg_wr_en_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .uframe_tick_i(uframe_tick_i),
    .irq_o        (irq_o),
    .cause_o      (cause_o),
    .cond_vec     (cond_vec),
    .latency      (lat_q)
);

// File: tb/done_group_irq_tb.sv
// Directed bench for done_group_irq: one task per scenario.
module done_group_irq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] d_iso = '0, d_per = '0, d_asy = '0;
    logic        tick = 1'b0;
    logic        irq;
    logic [2:0]  cause;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    done_group_irq dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .done_iso_i(d_iso), .done_per_i(d_per), .done_asy_i(d_asy),
        .uframe_tick_i(tick), .irq_o(irq), .cause_o(cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
        #1;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk); addr = a; #1;
        chk(tag, rdata, exp);
        addr = '0;
    endtask

    // One tick pulse; irq sampled inside the tick cycle
    task automatic pulse(input string tag, input logic exp_irq);
        @(negedge clk); tick = 1'b1; #1;
        chk(tag, {31'b0, irq}, {31'b0, exp_irq});
        @(negedge clk); tick = 1'b0; #1;
    endtask

    task automatic cleanup();
        d_iso = '0; d_per = '0; d_asy = '0;
        for (int a = 0; a < 7; a++) wr(4'(a), 32'h0);
        wr(4'd7, 32'h7);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 cause", {29'b0, cause}, 32'h0);
        for (int a = 0; a < 8; a++) rd_chk("R1 readback", 4'(a), 32'h0);
    endtask

    task automatic t_regs();
        wr(4'd0, 32'hA5A5_0001); wr(4'd3, 32'h1234_5678);
        wr(4'd5, 32'h8000_0000); wr(4'd6, 32'h0000_01FF);
        rd_chk("R2 all iso", 4'd0, 32'hA5A5_0001);
        rd_chk("R2 any per", 4'd3, 32'h1234_5678);
        rd_chk("R2 any asy", 4'd5, 32'h8000_0000);
        rd_chk("R2 latency 8 bits", 4'd6, 32'h0000_00FF);
        rd_chk("R2 unmapped", 4'd9, 32'h0);
        cleanup();
    endtask

    task automatic t_all_group();
        wr(4'd0, 32'h0000_00F0);
        @(negedge clk); d_iso = 32'h0000_0070; #1;
        chk("R3 partial group", {31'b0, irq}, 32'h0);
        @(negedge clk); d_iso = 32'h0000_00F0; #1;
        chk("R7 same-cycle irq", {31'b0, irq}, 32'h1);
        chk("R7 cause not yet", {29'b0, cause}, 32'h0);
        @(negedge clk); #1;
        chk("R3 cause iso", {29'b0, cause}, 32'h1);
        rd_chk("R2 cause readback", 4'd7, 32'h1);
        cleanup();
    endtask

    task automatic t_empty_all();
        @(negedge clk); d_per = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        #1;
        chk("R4 empty mask irq", {31'b0, irq}, 32'h0);
        chk("R4 empty mask cause", {29'b0, cause}, 32'h0);
        cleanup();
    endtask

    task automatic t_any();
        wr(4'd5, 32'h8000_0001);
        @(negedge clk); d_asy = 32'h0000_0001; #1;
        chk("R5 any irq", {31'b0, irq}, 32'h1);
        @(negedge clk); #1;
        chk("R12 only async cause", {29'b0, cause}, 32'h4);
        cleanup();
    endtask

    task automatic t_ignore();
        wr(4'd0, 32'h0000_00F0); wr(4'd1, 32'h0000_0100);
        @(negedge clk); d_iso = 32'hFFFF_FE0F; d_per = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        #1;
        chk("R6 unselected irq", {31'b0, irq}, 32'h0);
        chk("R6 unselected cause", {29'b0, cause}, 32'h0);
        cleanup();
    endtask

    task automatic t_latency();
        wr(4'd6, 32'd3); wr(4'd3, 32'h0000_0020);
        @(negedge clk); d_per = 32'h0000_0020; #1;
        chk("R8 no tick yet", {31'b0, irq}, 32'h0);
        pulse("R8 tick1 low", 1'b0);
        pulse("R8 tick2 low", 1'b0);
        pulse("R8 tick3 high", 1'b1);
        chk("R8 cause per", {29'b0, cause}, 32'h2);
        cleanup();
    endtask

    task automatic t_restart();
        wr(4'd6, 32'd3); wr(4'd1, 32'h0000_0002);
        @(negedge clk); d_iso = 32'h2;
        pulse("R9 tick1 low", 1'b0);
        pulse("R9 tick2 low", 1'b0);
        @(negedge clk); d_iso = 32'h0;
        @(negedge clk); d_iso = 32'h2;
        pulse("R9 restart tick1 low", 1'b0);
        pulse("R9 restart tick2 low", 1'b0);
        pulse("R9 restart tick3 high", 1'b1);
        cleanup();
    endtask

    task automatic t_sticky();
        wr(4'd1, 32'h0000_0004);
        @(negedge clk); d_iso = 32'h4;
        @(negedge clk); d_iso = 32'h0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 cause held", {29'b0, cause}, 32'h1);
        chk("R10 irq held", {31'b0, irq}, 32'h1);
        wr(4'd7, 32'h6);
        chk("R11 zero bits keep", {29'b0, cause}, 32'h1);
        wr(4'd7, 32'h1);
        chk("R11 cleared", {29'b0, cause}, 32'h0);
        chk("R11 irq low", {31'b0, irq}, 32'h0);
        cleanup();
    endtask

    task automatic t_refire();
        wr(4'd3, 32'h1);
        @(negedge clk); d_per = 32'h1;
        @(negedge clk); #1;
        chk("R11 fired", {29'b0, cause}, 32'h2);
        wr(4'd7, 32'h2);
        chk("R11 cleared bit", {29'b0, cause}, 32'h0);
        chk("R11 refire irq", {31'b0, irq}, 32'h1);
        @(negedge clk); #1;
        chk("R11 refire cause", {29'b0, cause}, 32'h2);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_all_group();
        t_empty_all();
        t_any();
        t_ignore();
        t_latency();
        t_restart();
        t_sticky();
        t_refire();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule